// File: doc/BRIEF.md
# I2C Control and Status Register Bank

This block is the register-side front end of an I2C controller. Software writes and reads it through a simple register bus. It keeps the controller's enable, start, stop, acknowledge-enable and interrupt-enable bits, a job-done flag, a write-collision flag, a 5-bit status code, a prescaler selection, a bit-rate divisor and the transmit data byte. The protocol engine behind it reports finished jobs, status codes, executed STOPs, bus availability and master/slave role. The block turns software actions into single-cycle command strobes for that engine.

The job-done flag follows a hand-off scheme. The engine raises it when it needs software. Software writes a one to release it, and that release is the command that lets the engine continue. Data-register writes are accepted only while the flag is up. A start request waits for a free bus. A stop request either runs a STOP as master or, in slave role, resets the engine to an idle unaddressed state.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0xF8, the data register output is 0x00, and irq, eng_enable and all command strobes are low.
- R2: A one-cycle eng_done pulse sets the job-done flag (control bit 7). A control write with bit 7 at zero leaves the flag set.
- R3: A control write with bit 7 at one, while the flag is set, clears the flag and raises cmd_go for exactly one cycle, starting the cycle after the write.
- R4: When eng_done and a control write of one to bit 7 occur in the same cycle, the flag stays set and cmd_go stays low.
- R5: irq is high exactly while both the interrupt-enable bit (control bit 0) and the job-done flag are set.
- R6: A write to the data register (address 2) while the flag is clear leaves tx_data unchanged and sets the collision flag (control bit 3). A data write while the flag is set loads tx_data and clears the collision flag.
- R7: A control write with start (bit 5) and enable (bit 2) both at one, while eng_bus_free is high, raises cmd_start for one cycle right after the write. The start bit reads back as one until software writes it to zero.
- R8: When the bus is busy at the start request, cmd_start stays low until eng_bus_free goes high and then pulses once.
- R9: A control write with stop (bit 4) and enable set while eng_master is high raises cmd_stop for one cycle. The stop bit reads one until an eng_stop_done pulse clears it.
- R10: The same stop write while eng_master is low raises cmd_slave_reset for one cycle, does not raise cmd_stop, and leaves the stop bit reading zero.
- R11: A control write with enable at zero drops eng_enable in the next cycle, cancels a pending start so that no cmd_start follows when the bus frees, and clears the stop bit.
- R12: The status register reads the code captured at the last eng_done in bits 7..3, zero in bit 2 and the prescaler in bits 1..0. Writes change only the prescaler, which also drives prescale_sel.
- R13: Control bits 3 and 1 cannot be written. Bit 1 always reads zero.
- R14: Control bit 6 drives eng_ack_en. A write to address 3 loads the bit-rate divisor on rate_div.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, valid with reg_sel |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 rate |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| eng_done | input | 1 | Engine finished its job (pulse) |
| eng_code | input | 5 | Status code captured on eng_done |
| eng_stop_done | input | 1 | STOP condition executed (pulse) |
| eng_bus_free | input | 1 | Bus idle level |
| eng_master | input | 1 | Engine is in master role |
| irq | output | 1 | Interrupt request |
| cmd_go | output | 1 | Continue strobe after flag release |
| cmd_start | output | 1 | Generate START strobe |
| cmd_stop | output | 1 | Generate STOP strobe |
| cmd_slave_reset | output | 1 | Return to unaddressed slave strobe |
| eng_enable | output | 1 | Engine enable and pin ownership |
| eng_ack_en | output | 1 | Acknowledge enable |
| tx_data | output | 8 | Data register contents |
| rate_div | output | 8 | Bit-rate divisor |
| prescale_sel | output | 2 | Prescaler selection |

## Verification
The engine's job-done pulse and a software write that releases the flag can land in the same cycle. The two requests pull the flag in opposite directions. The bench lines up both on one clock edge, with the flag already set, and expects the flag to remain set with no continue strobe. A second pairing is a data-register write in the very cycle the flag moves. The write is judged by the flag value held before that edge, which the collision tests rely on.

// File: rtl/i2c_cr_pkg.sv
package i2c_cr_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int CODE_W  = 5;
  localparam int PRESC_W = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_DATA = 2'd2;
  localparam logic [AW-1:0] A_RATE = 2'd3;

  localparam int B_DONE = 7;
  localparam int B_ACK  = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_WCOL = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;

  localparam logic [CODE_W-1:0] CODE_IDLE = '1;
endpackage

// File: rtl/i2c_cr_flags.sv
module i2c_cr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_done,
  input  logic sw_release,
  input  logic dat_wr,
  input  logic ie,
  output logic done,
  output logic wcol,
  output logic go,
  output logic irq,
  output logic dat_accept
);
  logic done_q, done_n, wcol_q, wcol_n, go_q, go_n;

  always_comb begin
    done_n = done_q;
    go_n   = 1'b0;
    if (hw_done) begin
      done_n = 1'b1;
    end else if (sw_release && done_q) begin
      done_n = 1'b0;
      go_n   = 1'b1;
    end
    wcol_n = wcol_q;
    if (dat_wr) wcol_n = !done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      done_q <= done_n;
      wcol_q <= wcol_n;
      go_q   <= go_n;
    end
  end

  assign done       = done_q;
  assign wcol       = wcol_q;
  assign go         = go_q;
  assign irq        = done_q & ie;
  assign dat_accept = dat_wr & done_q;
endmodule

// File: rtl/i2c_cr_seq.sv
module i2c_cr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_sta,
  input  logic wr_sto,
  input  logic wr_en,
  input  logic en,
  input  logic is_master,
  input  logic bus_free,
  input  logic stop_done,
  output logic start_pend,
  output logic sto,
  output logic cmd_start,
  output logic cmd_stop,
  output logic cmd_slave_reset
);
  logic pend_q, pend_n, sto_q, sto_n, stp_q, stp_n, srst_q, srst_n;
  logic fire;

  assign fire = pend_q & bus_free & en;

  always_comb begin
    pend_n = pend_q;
    sto_n  = sto_q;
    stp_n  = 1'b0;
    srst_n = 1'b0;
    if (fire) pend_n = 1'b0;
    if (stop_done) sto_n = 1'b0;
    if (ctrl_wr) begin
      if (!wr_en) begin
        pend_n = 1'b0;
        sto_n  = 1'b0;
      end else begin
        if (wr_sta) pend_n = 1'b1;
        if (wr_sto) begin
          if (is_master) begin
            sto_n = 1'b1;
            stp_n = 1'b1;
          end else begin
            sto_n  = 1'b0;
            srst_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sto_q  <= 1'b0;
      stp_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      sto_q  <= sto_n;
      stp_q  <= stp_n;
      srst_q <= srst_n;
    end
  end

  assign start_pend      = pend_q;
  assign sto             = sto_q;
  assign cmd_start       = fire;
  assign cmd_stop        = stp_q;
  assign cmd_slave_reset = srst_q;
endmodule

// File: rtl/i2c_cr_bank.sv
module i2c_cr_bank
  import i2c_cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic              rate_wr,
  input  logic              dat_accept,
  input  logic [DW-1:0]     wdata,
  input  logic              hw_done,
  input  logic [CODE_W-1:0] hw_code,
  output logic              ack_en,
  output logic              sta,
  output logic              en,
  output logic              ie,
  output logic [CODE_W-1:0] code,
  output logic [PRESC_W-1:0] presc,
  output logic [DW-1:0]     data,
  output logic [DW-1:0]     rate
);
  logic              ack_q, sta_q, en_q, ie_q;
  logic              ack_n, sta_n, en_n, ie_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [PRESC_W-1:0] presc_q, presc_n;
  logic [DW-1:0]     data_q, data_n, rate_q, rate_n;

  always_comb begin
    ack_n   = ack_q;
    sta_n   = sta_q;
    en_n    = en_q;
    ie_n    = ie_q;
    code_n  = code_q;
    presc_n = presc_q;
    data_n  = data_q;
    rate_n  = rate_q;
    if (ctrl_wr) begin
      ack_n = wdata[B_ACK];
      sta_n = wdata[B_STA];
      en_n  = wdata[B_EN];
      ie_n  = wdata[B_IE];
    end
    if (stat_wr)    presc_n = wdata[PRESC_W-1:0];
    if (rate_wr)    rate_n  = wdata;
    if (dat_accept) data_n  = wdata;
    if (hw_done)    code_n  = hw_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      sta_q   <= 1'b0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      code_q  <= CODE_IDLE;
      presc_q <= '0;
      data_q  <= '0;
      rate_q  <= '0;
    end else begin
      ack_q   <= ack_n;
      sta_q   <= sta_n;
      en_q    <= en_n;
      ie_q    <= ie_n;
      code_q  <= code_n;
      presc_q <= presc_n;
      data_q  <= data_n;
      rate_q  <= rate_n;
    end
  end

  assign ack_en = ack_q;
  assign sta    = sta_q;
  assign en     = en_q;
  assign ie     = ie_q;
  assign code   = code_q;
  assign presc  = presc_q;
  assign data   = data_q;
  assign rate   = rate_q;
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
  import i2c_cr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               eng_done,
  input  logic [CODE_W-1:0]  eng_code,
  input  logic               eng_stop_done,
  input  logic               eng_bus_free,
  input  logic               eng_master,
  output logic               irq,
  output logic               cmd_go,
  output logic               cmd_start,
  output logic               cmd_stop,
  output logic               cmd_slave_reset,
  output logic               eng_enable,
  output logic               eng_ack_en,
  output logic [DW-1:0]      tx_data,
  output logic [DW-1:0]      rate_div,
  output logic [PRESC_W-1:0] prescale_sel
);
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic wr_any, ctrl_wr, stat_wr, dat_wr, rate_wr, sw_release, dat_accept;
  assign wr_any     = reg_sel & reg_wr;
  assign ctrl_wr    = wr_any && (reg_addr == A_CTRL);
  assign stat_wr    = wr_any && (reg_addr == A_STAT);
  assign dat_wr     = wr_any && (reg_addr == A_DATA);
  assign rate_wr    = wr_any && (reg_addr == A_RATE);
  assign sw_release = ctrl_wr & reg_wdata[B_DONE];

  logic flag_done, flag_wcol, start_pend, sto_bit, sta_bit, en_bit, ie_bit;
  logic [CODE_W-1:0] code;

  i2c_cr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_q),
    .hw_done    (eng_done),
    .sw_release (sw_release),
    .dat_wr     (dat_wr),
    .ie         (ie_bit),
    .done       (flag_done),
    .wcol       (flag_wcol),
    .go         (cmd_go),
    .irq        (irq),
    .dat_accept (dat_accept)
  );

  i2c_cr_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_q),
    .ctrl_wr         (ctrl_wr),
    .wr_sta          (reg_wdata[B_STA]),
    .wr_sto          (reg_wdata[B_STO]),
    .wr_en           (reg_wdata[B_EN]),
    .en              (en_bit),
    .is_master       (eng_master),
    .bus_free        (eng_bus_free),
    .stop_done       (eng_stop_done),
    .start_pend      (start_pend),
    .sto             (sto_bit),
    .cmd_start       (cmd_start),
    .cmd_stop        (cmd_stop),
    .cmd_slave_reset (cmd_slave_reset)
  );

  i2c_cr_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_q),
    .ctrl_wr    (ctrl_wr),
    .stat_wr    (stat_wr),
    .rate_wr    (rate_wr),
    .dat_accept (dat_accept),
    .wdata      (reg_wdata),
    .hw_done    (eng_done),
    .hw_code    (eng_code),
    .ack_en     (eng_ack_en),
    .sta        (sta_bit),
    .en         (en_bit),
    .ie         (ie_bit),
    .code       (code),
    .presc      (prescale_sel),
    .data       (tx_data),
    .rate       (rate_div)
  );

  assign eng_enable = en_bit;

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {flag_done, eng_ack_en, sta_bit, sto_bit,
                            flag_wcol, en_bit, 1'b0, ie_bit};
      A_STAT:  reg_rdata = {code, 1'b0, prescale_sel};
      A_DATA:  reg_rdata = tx_data;
      default: reg_rdata = rate_div;
    endcase
  end
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
module i2c_ctrl_regs_chk (
  input logic clk,
  input logic rst_q,
  input logic irq,
  input logic flag_done,
  input logic flag_wcol,
  input logic sto_bit,
  input logic cmd_go,
  input logic cmd_start,
  input logic cmd_stop,
  input logic cmd_slave_reset,
  input logic eng_done,
  input logic eng_stop_done,
  input logic eng_bus_free,
  input logic eng_enable,
  input logic ctrl_wr,
  input logic dat_wr
);
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> flag_done);
  p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_go |=> !cmd_go);
  p_hw_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_q)
    eng_done |=> flag_done);
  p_collision_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (dat_wr && !flag_done) |=> flag_wcol);
  p_start_free_r8: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_start |-> eng_bus_free);
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (sto_bit && !eng_stop_done && !ctrl_wr) |=> sto_bit);
  p_slave_no_stop_r10: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_slave_reset |-> !cmd_stop);
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !eng_enable |-> (!cmd_start && !sto_bit));
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk chk_i (
  .clk             (clk),
  .rst_q           (rst_q),
  .irq             (irq),
  .flag_done       (flag_done),
  .flag_wcol       (flag_wcol),
  .sto_bit         (sto_bit),
  .cmd_go          (cmd_go),
  .cmd_start       (cmd_start),
  .cmd_stop        (cmd_stop),
  .cmd_slave_reset (cmd_slave_reset),
  .eng_done        (eng_done),
  .eng_stop_done   (eng_stop_done),
  .eng_bus_free    (eng_bus_free),
  .eng_enable      (eng_enable),
  .ctrl_wr         (ctrl_wr),
  .dat_wr          (dat_wr)
);

// File: tb/i2c_ctrl_regs_tb_top.sv
module i2c_ctrl_regs_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_sel, reg_wr, eng_done, eng_stop_done, eng_bus_free, eng_master;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, tx_data, rate_div;
  logic [4:0] eng_code;
  logic [1:0] prescale_sel;
  logic irq, cmd_go, cmd_start, cmd_stop, cmd_slave_reset, eng_enable, eng_ack_en;

  int n_chk = 0;
  int n_bad = 0;

  i2c_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done(eng_done), .eng_code(eng_code), .eng_stop_done(eng_stop_done),
    .eng_bus_free(eng_bus_free), .eng_master(eng_master), .irq(irq),
    .cmd_go(cmd_go), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_slave_reset(cmd_slave_reset), .eng_enable(eng_enable),
    .eng_ack_en(eng_ack_en), .tx_data(tx_data), .rate_div(rate_div),
    .prescale_sel(prescale_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_done(input logic [4:0] c);
    @(negedge clk);
    eng_done = 1'b1; eng_code = c;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1", "ctrl", v, 8'h00);
    rd(2'd1, v); check("R1", "status", v, 8'hF8);
    check("R1", "tx_data", tx_data, 8'h00);
    check("R1", "outs", {irq, eng_enable, cmd_go, cmd_start, cmd_stop, cmd_slave_reset},
          8'h00);
  endtask

  task automatic t_done_flag;
    logic [7:0] v;
    wr(2'd0, 8'h05);
    check("R5", "irq no flag", {7'd0, irq}, 8'h00);
    pulse_done(5'h08);
    rd(2'd0, v); check("R2", "flag set", v, 8'h85);
    check("R5", "irq on", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check("R12", "code captured", v, 8'h40);
    wr(2'd0, 8'h05);
    rd(2'd0, v); check("R2", "write zero keeps flag", v[7:0] & 8'h80, 8'h80);
    wr(2'd0, 8'h85);
    check("R3", "go pulse", {7'd0, cmd_go}, 8'h01);
    rd(2'd0, v); check("R3", "flag cleared", v & 8'h80, 8'h00);
    check("R5", "irq off", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R3", "go one cycle", {7'd0, cmd_go}, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    wr(2'd2, 8'h5A);
    check("R6", "refused", tx_data, 8'h00);
    rd(2'd0, v); check("R6", "wcol set", v & 8'h08, 8'h08);
    pulse_done(5'h10);
    wr(2'd2, 8'hA5);
    check("R6", "accepted", tx_data, 8'hA5);
    rd(2'd0, v); check("R6", "wcol cleared", v & 8'h08, 8'h00);
  endtask

  task automatic t_hw_wins;
    logic [7:0] v;
    @(negedge clk);
    eng_done = 1'b1; eng_code = 5'h10;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h85;
    @(negedge clk);
    eng_done = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); check("R4", "flag kept", v & 8'h80, 8'h80);
    check("R4", "no go", {7'd0, cmd_go}, 8'h00);
    wr(2'd0, 8'h85);
    check("R3", "later release", {7'd0, cmd_go}, 8'h01);
  endtask

  task automatic t_start_free;
    logic [7:0] v;
    eng_bus_free = 1'b1;
    wr(2'd0, 8'h24);
    #0.5;
    check("R7", "start now", {7'd0, cmd_start}, 8'h01);
    @(negedge clk); #0.5;
    check("R7", "start once", {7'd0, cmd_start}, 8'h00);
    rd(2'd0, v); check("R7", "sta held", v & 8'h20, 8'h20);
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R7", "sta cleared", v & 8'h20, 8'h00);
  endtask

  task automatic t_start_busy;
    eng_bus_free = 1'b0;
    wr(2'd0, 8'h24);
    for (int i = 0; i < 3; i++) begin
      #0.5;
      check("R8", "waits busy", {7'd0, cmd_start}, 8'h00);
      @(negedge clk);
    end
    eng_bus_free = 1'b1;
    #0.5;
    check("R8", "start on free", {7'd0, cmd_start}, 8'h01);
    @(negedge clk); #0.5;
    check("R8", "single start", {7'd0, cmd_start}, 8'h00);
    wr(2'd0, 8'h04);
  endtask

  task automatic t_stop_master;
    logic [7:0] v;
    eng_master = 1'b1;
    wr(2'd0, 8'h14);
    check("R9", "stop strobe", {7'd0, cmd_stop}, 8'h01);
    rd(2'd0, v); check("R9", "sto set", v & 8'h10, 8'h10);
    @(negedge clk);
    check("R9", "stop one cycle", {7'd0, cmd_stop}, 8'h00);
    rd(2'd0, v); check("R9", "sto held", v & 8'h10, 8'h10);
    eng_stop_done = 1'b1;
    @(negedge clk);
    eng_stop_done = 1'b0;
    rd(2'd0, v); check("R9", "sto auto clear", v & 8'h10, 8'h00);
  endtask

  task automatic t_stop_slave;
    logic [7:0] v;
    eng_master = 1'b0;
    wr(2'd0, 8'h14);
    check("R10", "slave reset", {7'd0, cmd_slave_reset}, 8'h01);
    check("R10", "no stop", {7'd0, cmd_stop}, 8'h00);
    rd(2'd0, v); check("R10", "sto zero", v & 8'h10, 8'h00);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    eng_master = 1'b1;
    eng_bus_free = 1'b0;
    wr(2'd0, 8'h34);
    wr(2'd0, 8'h00);
    check("R11", "enable low", {7'd0, eng_enable}, 8'h00);
    rd(2'd0, v); check("R11", "sto cleared", v & 8'h10, 8'h00);
    eng_bus_free = 1'b1;
    #0.5;
    check("R11", "start cancelled", {7'd0, cmd_start}, 8'h00);
    @(negedge clk); #0.5;
    check("R11", "still none", {7'd0, cmd_start}, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R12", "status layout", v, 8'h83);
    check("R12", "prescale out", {6'd0, prescale_sel}, 8'h03);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    wr(2'd0, 8'h0E);
    rd(2'd0, v); check("R13", "ro bits", v & 8'h0A, 8'h00);
    check("R13", "enable took", {7'd0, eng_enable}, 8'h01);
  endtask

  task automatic t_ack_rate;
    wr(2'd0, 8'h44);
    check("R14", "ack on", {7'd0, eng_ack_en}, 8'h01);
    wr(2'd0, 8'h04);
    check("R14", "ack off", {7'd0, eng_ack_en}, 8'h00);
    wr(2'd3, 8'h37);
    check("R14", "rate", rate_div, 8'h37);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    eng_done = 1'b0; eng_code = 5'h00; eng_stop_done = 1'b0;
    eng_bus_free = 1'b1; eng_master = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_done_flag();
    t_collision();
    t_hw_wins();
    t_start_free();
    t_start_busy();
    t_stop_master();
    t_stop_slave();
    t_disable();
    t_status();
    t_readonly();
    t_ack_rate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule